// File: doc/BRIEF.md
# Chained Transfer Descriptor Engine

This block walks a linked run of transfer descriptors held in host memory and turns each into a word-count request for a data mover serving one direction of a link channel. Software programs a 16-byte aligned queue base and writes a start command. The engine then reads each entry's two words over a synchronous request/acknowledge memory read port. It issues one mover request per entry that carries data and stops after the entry whose end flag is set.

Entries can be individually skipped, and zero-length entries complete without touching the mover. An interrupt enable given with the start command decides whether chain completion sets a sticky status bit. That bit drives `irq_o` and is cleared only by writing 1 to it. A soft-reset command bit aborts a running chain and returns the block to its reset state. The register port is word-selected: offset 0 is control, 1 is queue base, 2 is interrupt status.

Top module: `dsc_chain_engine`

## Requirements
- R1: The queue base register (offset 1) keeps bits 31..4 of a write and reads 0 in bits 3..0; the first memory fetch after start is at that base.
- R2: An entry is two consecutive words: the buffer address at the entry pointer, then a flags word at pointer+4 with length in 32-bit words in bits 23..0, skip in bit 30 and end-of-chain in bit 31; the next entry sits at pointer+8.
- R3: For each entry with skip clear and nonzero length, exactly one mover request is raised carrying the entry's buffer address and word count, held stable until `mv_done_i`; requests come in chain order.
- R4: An entry with its skip bit set produces no mover request and the engine proceeds to the following entry.
- R5: An entry with a length of zero produces no mover request.
- R6: After the entry with the end bit set, whether moved, skipped or empty, the engine goes idle and the busy bit (control bit 8) reads 0; no memory or mover request is raised while idle.
- R7: Writing control bit 0 starts a chain; bit 2 in the same write enables the completion interrupt. When enabled, completion sets status bit 0 (offset 2) and `irq_o`; a write of 0 leaves it set, a write of 1 clears it; a chain started with bit 2 clear leaves it unchanged.
- R8: A start write while busy is ignored: the running chain is neither restarted nor repeated, and busy stays 1 until it ends.
- R9: Writing 1 to control bit 1 aborts any chain and clears busy, the queue base and the interrupt status in that cycle; writing 0 to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 2 | Register write word select |
| reg_wdata_i | input | 32 | Register write data |
| reg_raddr_i | input | 2 | Register read word select |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mem_req_o | output | 1 | Memory read request, held until acknowledge |
| mem_addr_o | output | AW | Memory read byte address |
| mem_ack_i | input | 1 | Memory read acknowledge, data valid |
| mem_rdata_i | input | 32 | Memory read data |
| mv_req_o | output | 1 | Data mover request, held until done |
| mv_addr_o | output | AW | Buffer address for the mover |
| mv_words_o | output | LW | Word count for the mover |
| mv_done_i | input | 1 | Data mover completion pulse |
| irq_o | output | 1 | Interrupt, equal to status bit 0 |

## Verification
Chains are built in a bench memory and the issued mover requests are compared with a list derived from the same memory: a plain three-entry chain checks ordering and address stepping, a chain mixing skipped and zero-length entries separates both kinds of suppression from the end condition, and a single maximum-length entry checks the full 24-bit count. A lone skipped end entry shows that the end flag is honoured even when no data moves. Interrupt tests run with the enable both set and clear and write 0 then 1 to the status bit. A second start during a slow mover and a soft reset mid-transfer show that the busy window protects the running chain and that the abort clears all state.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned REG_CTRL  = 0;
  localparam int unsigned REG_QBASE = 1;
  localparam int unsigned REG_STAT  = 2;

  localparam int unsigned CTRL_START = 0;
  localparam int unsigned CTRL_SRST  = 1;
  localparam int unsigned CTRL_IEN   = 2;
  localparam int unsigned CTRL_BUSY  = 8;

  localparam int unsigned FLG_SKIP = 30;
  localparam int unsigned FLG_END  = 31;

  localparam int unsigned QALIGN_BITS = 4;
  localparam int unsigned ENTRY_BYTES = 8;
  localparam int unsigned FLAGS_OFS   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_ADDR,
    ST_FETCH_FLAGS,
    ST_DECIDE,
    ST_MOVE
  } walk_state_e;
endpackage

// File: rtl/dsc_regs.sv
module dsc_regs
  import dsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [1:0]    waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    raddr_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          irq_set_i,
  output logic          start_o,
  output logic          start_ien_o,
  output logic          srst_o,
  output logic [AW-1:0] base_o,
  output logic          irq_o
);
  logic [AW-1:0] qbase_q;
  logic          irq_q;
  logic          ctrl_wr, qbase_wr, stat_wr;

  assign ctrl_wr  = we_i && (waddr_i == 2'(REG_CTRL));
  assign qbase_wr = we_i && (waddr_i == 2'(REG_QBASE));
  assign stat_wr  = we_i && (waddr_i == 2'(REG_STAT));

  assign srst_o      = ctrl_wr && wdata_i[CTRL_SRST];
  assign start_o     = ctrl_wr && wdata_i[CTRL_START] && !busy_i && !srst_o;
  assign start_ien_o = wdata_i[CTRL_IEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qbase_q <= '0;
      irq_q   <= 1'b0;
    end else if (srst_o) begin
      qbase_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      if (qbase_wr)
        qbase_q <= {wdata_i[AW-1:QALIGN_BITS], {QALIGN_BITS{1'b0}}};
      // set beats a same-cycle clear
      if (irq_set_i)
        irq_q <= 1'b1;
      else if (stat_wr && wdata_i[0])
        irq_q <= 1'b0;
    end
  end

  assign base_o = qbase_q;
  assign irq_o  = irq_q;

  always_comb begin
    rdata_o = '0;
    unique case (raddr_i)
      2'(REG_CTRL):  rdata_o[CTRL_BUSY] = busy_i;
      2'(REG_QBASE): rdata_o[AW-1:0]    = qbase_q;
      2'(REG_STAT):  rdata_o[0]         = irq_q;
      default:       rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/dsc_walker.sv
module dsc_walker
  import dsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned LW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          srst_i,
  input  logic          start_i,
  input  logic          start_ien_i,
  input  logic [AW-1:0] base_i,
  output logic          busy_o,
  output logic          irq_set_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          mv_req_o,
  output logic [AW-1:0] mv_addr_o,
  output logic [LW-1:0] mv_words_o,
  input  logic          mv_done_i
);
  walk_state_e   state_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] buf_q;
  logic [DW-1:0] flags_q;
  logic          ien_q;
  logic          irq_set_q;
  logic          no_move, is_end;

  assign no_move = flags_q[FLG_SKIP] || (flags_q[LW-1:0] == '0);
  assign is_end  = flags_q[FLG_END];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      buf_q     <= '0;
      flags_q   <= '0;
      ien_q     <= 1'b0;
      irq_set_q <= 1'b0;
    end else if (srst_i) begin
      state_q   <= ST_IDLE;
      ptr_q     <= '0;
      buf_q     <= '0;
      flags_q   <= '0;
      ien_q     <= 1'b0;
      irq_set_q <= 1'b0;
    end else begin
      irq_set_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          ptr_q   <= base_i;
          ien_q   <= start_ien_i;
          state_q <= ST_FETCH_ADDR;
        end
        ST_FETCH_ADDR: if (mem_ack_i) begin
          buf_q   <= mem_rdata_i[AW-1:0];
          state_q <= ST_FETCH_FLAGS;
        end
        ST_FETCH_FLAGS: if (mem_ack_i) begin
          flags_q <= mem_rdata_i;
          state_q <= ST_DECIDE;
        end
        ST_DECIDE, ST_MOVE: begin
          if ((state_q == ST_DECIDE && no_move) || (state_q == ST_MOVE && mv_done_i)) begin
            if (is_end) begin
              state_q   <= ST_IDLE;
              irq_set_q <= ien_q;
            end else begin
              ptr_q   <= ptr_q + AW'(ENTRY_BYTES);
              state_q <= ST_FETCH_ADDR;
            end
          end else if (state_q == ST_DECIDE) begin
            state_q <= ST_MOVE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign irq_set_o  = irq_set_q;
  assign mem_req_o  = (state_q == ST_FETCH_ADDR) || (state_q == ST_FETCH_FLAGS);
  assign mem_addr_o = (state_q == ST_FETCH_FLAGS) ? ptr_q + AW'(FLAGS_OFS) : ptr_q;
  assign mv_req_o   = (state_q == ST_MOVE);
  assign mv_addr_o  = buf_q;
  assign mv_words_o = flags_q[LW-1:0];
endmodule

// File: rtl/dsc_chain_engine.sv
module dsc_chain_engine
  import dsc_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_waddr_i,
  input  logic [31:0]   reg_wdata_i,
  input  logic [1:0]    reg_raddr_i,
  output logic [31:0]   reg_rdata_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ack_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          mv_req_o,
  output logic [AW-1:0] mv_addr_o,
  output logic [LW-1:0] mv_words_o,
  input  logic          mv_done_i,
  output logic          irq_o
);
  localparam int unsigned DW = 32;

  logic          busy, irq_set, start, start_ien, srst;
  logic [AW-1:0] base;

  dsc_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .waddr_i     (reg_waddr_i),
    .wdata_i     (reg_wdata_i),
    .raddr_i     (reg_raddr_i),
    .rdata_o     (reg_rdata_o),
    .busy_i      (busy),
    .irq_set_i   (irq_set),
    .start_o     (start),
    .start_ien_o (start_ien),
    .srst_o      (srst),
    .base_o      (base),
    .irq_o       (irq_o)
  );

  dsc_walker #(.AW(AW), .DW(DW), .LW(LW)) u_walker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .srst_i      (srst),
    .start_i     (start),
    .start_ien_i (start_ien),
    .base_i      (base),
    .busy_o      (busy),
    .irq_set_o   (irq_set),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .mv_req_o    (mv_req_o),
    .mv_addr_o   (mv_addr_o),
    .mv_words_o  (mv_words_o),
    .mv_done_i   (mv_done_i)
  );
endmodule

// File: rtl/dsc_chain_engine_chk.sv
module dsc_chain_engine_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          reg_we_i,
  input logic [1:0]    reg_waddr_i,
  input logic [31:0]   reg_wdata_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_ack_i,
  input logic          mv_req_o,
  input logic [AW-1:0] mv_addr_o,
  input logic [LW-1:0] mv_words_o,
  input logic          mv_done_i,
  input logic          irq_o,
  input logic          busy
);
  logic srst_wr, clr_wr;
  assign srst_wr = reg_we_i && (reg_waddr_i == 2'd0) && reg_wdata_i[1];
  assign clr_wr  = reg_we_i && (reg_waddr_i == 2'd2) && reg_wdata_i[0];

  p_mem_addr_word_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  p_mem_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !srst_wr) |=> (mem_req_o && $stable(mem_addr_o)));

  p_mv_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mv_req_o && !mv_done_i && !srst_wr) |=> (mv_req_o && $stable(mv_addr_o) && $stable(mv_words_o)));

  p_one_port_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_req_o && mv_req_o));

  p_no_empty_move_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mv_req_o |-> (mv_words_o != '0));

  p_idle_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (!mem_req_o && !mv_req_o));

  p_irq_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_wr && !srst_wr) |=> irq_o);

  p_soft_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_wr |=> (!busy && !irq_o));
endmodule

bind dsc_chain_engine dsc_chain_engine_chk #(.AW(AW), .LW(LW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_waddr_i (reg_waddr_i),
  .reg_wdata_i (reg_wdata_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .mv_req_o    (mv_req_o),
  .mv_addr_o   (mv_addr_o),
  .mv_words_o  (mv_words_o),
  .mv_done_i   (mv_done_i),
  .irq_o       (irq_o),
  .busy        (busy)
);

// File: tb/dsc_chain_engine_bench.sv
`timescale 1ns/1ps
module dsc_chain_engine_bench;
  localparam int AW = 32;
  localparam int LW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          we = 1'b0;
  logic [1:0]    waddr = '0;
  logic [31:0]   wdata = '0;
  logic [1:0]    raddr = '0;
  logic [31:0]   rdata;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          mv_req;
  logic [AW-1:0] mv_addr;
  logic [LW-1:0] mv_words;
  logic          mv_done = 1'b0;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  logic [31:0] mem [0:63];
  logic [31:0] log_addr  [0:15];
  logic [23:0] log_words [0:15];
  int          log_n = 0;
  logic [31:0] exp_addr  [0:15];
  logic [23:0] exp_words [0:15];
  int          exp_n;
  int          mv_lat = 0;
  int          mv_cnt = 0;

  always #4 clk = ~clk;

  dsc_chain_engine #(.AW(AW), .LW(LW)) u_dsc_chain_engine (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_waddr_i(waddr), .reg_wdata_i(wdata),
    .reg_raddr_i(raddr), .reg_rdata_o(rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .mv_req_o(mv_req), .mv_addr_o(mv_addr), .mv_words_o(mv_words), .mv_done_i(mv_done),
    .irq_o(irq)
  );

  // memory responder: one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[7:2]];
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // mover model: logs each request at the cycle it completes
  always @(posedge clk) begin
    if (mv_req && !mv_done) begin
      if (mv_cnt >= mv_lat) begin
        mv_done <= 1'b1;
        mv_cnt  <= 0;
        if (log_n < 16) begin
          log_addr[log_n]  <= mv_addr;
          log_words[log_n] <= mv_words;
        end
        log_n <= log_n + 1;
      end else begin
        mv_cnt <= mv_cnt + 1;
      end
    end else begin
      mv_done <= 1'b0;
      if (!mv_req) mv_cnt <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; waddr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    raddr = a; #1; d = rdata;
  endtask

  task automatic put_entry(input int idx, input logic [31:0] a, input logic [23:0] len,
                           input bit skip, input bit last);
    mem[idx]     = a;
    mem[idx + 1] = {last, skip, 6'd0, len};
  endtask

  // reference: walk the bench memory by the rules of R2..R6
  task automatic build_expected(input logic [31:0] base);
    int idx = int'(base[7:2]);
    exp_n = 0;
    for (int k = 0; k < 16; k++) begin
      logic [31:0] f = mem[idx + 1];
      if (!f[30] && f[23:0] != 0) begin
        exp_addr[exp_n]  = mem[idx];
        exp_words[exp_n] = f[23:0];
        exp_n++;
      end
      if (f[31]) break;
      idx += 2;
    end
  endtask

  task automatic wait_idle();
    logic [31:0] d;
    for (int t = 0; t < 5000; t++) begin
      @(negedge clk);
      rd(2'd0, d);
      if (!d[8]) break;
    end
  endtask

  task automatic run_chain(input logic [31:0] base, input bit ien);
    log_n = 0;
    wr(2'd1, base);
    wr(2'd0, {29'd0, ien, 2'b01});
    wait_idle();
    @(negedge clk);
  endtask

  task automatic compare_log(input string req);
    chk(log_n == exp_n, req, 32'(log_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < log_n; i++) begin
      chk(log_addr[i] == exp_addr[i], req, log_addr[i], exp_addr[i]);
      chk(log_words[i] == exp_words[i], req, 32'(log_words[i]), 32'(exp_words[i]));
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(2'd0, d); chk(d[8] == 1'b0, "R6 reset busy", d, 0);
    rd(2'd1, d); chk(d == 0, "R1 reset qbase", d, 0);
    chk(irq == 1'b0 && !mv_req && !mem_req, "R7 reset outputs", {irq, mv_req, mem_req}, 0);
  endtask

  task automatic t_qbase_align();
    logic [31:0] d;
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, d); chk(d == 32'hFFFF_FFF0, "R1 qbase low bits", d, 32'hFFFF_FFF0);
  endtask

  task automatic t_plain_chain();
    logic [31:0] d;
    put_entry(8, 32'h1000_0000, 24'd4, 0, 0);
    put_entry(10, 32'h2000_0040, 24'd17, 0, 0);
    put_entry(12, 32'h3000_0100, 24'd1, 0, 1);
    build_expected(32'h20);
    run_chain(32'h20, 1'b1);
    compare_log("R2 R3 plain chain order");
    rd(2'd0, d); chk(d[8] == 1'b0, "R6 idle after end", d, 0);
    chk(irq == 1'b1, "R7 irq set on completion", 32'(irq), 1);
    rd(2'd2, d); chk(d[0] == 1'b1, "R7 status bit", d, 1);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(2'd2, 32'h0);
    rd(2'd2, d); chk(d[0] == 1'b1, "R7 write 0 keeps irq", d, 1);
    wr(2'd2, 32'h1);
    rd(2'd2, d); chk(d[0] == 1'b0 && irq == 1'b0, "R7 write 1 clears irq", d, 0);
  endtask

  task automatic t_skip_zero();
    put_entry(16, 32'h4000_0000, 24'd8, 1, 0);
    put_entry(18, 32'h4100_0000, 24'd0, 0, 0);
    put_entry(20, 32'h4200_0000, 24'd3, 0, 0);
    put_entry(22, 32'h4300_0000, 24'd9, 1, 0);
    put_entry(24, 32'h4400_0000, 24'd5, 0, 1);
    build_expected(32'h40);
    run_chain(32'h40, 1'b0);
    compare_log("R4 R5 skip and zero entries");
    chk(log_n == 2, "R4 only unskipped nonzero moved", 32'(log_n), 2);
    chk(irq == 1'b0, "R7 disabled irq stays clear", 32'(irq), 0);
  endtask

  task automatic t_max_len();
    put_entry(32, 32'h5555_AAA0, 24'hFF_FFFF, 0, 1);
    build_expected(32'h80);
    run_chain(32'h80, 1'b1);
    compare_log("R2 full 24-bit length");
    wr(2'd2, 32'h1);
  endtask

  task automatic t_skip_end();
    logic [31:0] d;
    put_entry(36, 32'h6000_0000, 24'd7, 1, 1);
    put_entry(38, 32'h6100_0000, 24'd7, 0, 1);
    run_chain(32'h90, 1'b1);
    chk(log_n == 0, "R6 skipped end entry ends chain", 32'(log_n), 0);
    rd(2'd0, d); chk(d[8] == 1'b0, "R6 idle after skipped end", d, 0);
    chk(irq == 1'b1, "R7 irq after skipped end", 32'(irq), 1);
    wr(2'd2, 32'h1);
  endtask

  task automatic t_start_busy();
    logic [31:0] d;
    mv_lat = 6;
    put_entry(40, 32'h7000_0000, 24'd2, 0, 0);
    put_entry(42, 32'h7100_0000, 24'd6, 0, 1);
    put_entry(44, 32'h7200_0000, 24'd1, 0, 1);
    build_expected(32'hA0);
    log_n = 0;
    wr(2'd1, 32'hA0);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk(d[8] == 1'b1, "R8 busy during chain", d, 32'h100);
    wr(2'd1, 32'hB0);
    wr(2'd0, 32'h1);
    rd(2'd0, d); chk(d[8] == 1'b1, "R8 busy after ignored start", d, 32'h100);
    wait_idle();
    @(negedge clk);
    compare_log("R8 start while busy ignored");
    mv_lat = 0;
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    put_entry(48, 32'h8000_0000, 24'd1, 0, 1);
    run_chain(32'hC0, 1'b1);
    chk(irq == 1'b1, "R9 irq set before reset", 32'(irq), 1);
    wr(2'd0, 32'h0);
    rd(2'd1, d); chk(d == 32'hC0, "R9 reset bit 0 no effect", d, 32'hC0);
    chk(irq == 1'b1, "R9 reset bit 0 keeps irq", 32'(irq), 1);
    mv_lat = 30;
    put_entry(50, 32'h8100_0000, 24'd4, 0, 1);
    wr(2'd1, 32'hC8 & 32'hFFFF_FFF0);
    mem[50] = 32'h8100_0000;
    wr(2'd1, 32'hC0);
    mem[48] = 32'h8100_0000; mem[49] = {1'b1, 1'b0, 6'd0, 24'd4};
    log_n = 0;
    wr(2'd0, 32'h1);
    for (int t = 0; t < 50 && !mv_req; t++) @(negedge clk);
    chk(mv_req == 1'b1, "R9 mover busy before abort", 32'(mv_req), 1);
    wr(2'd0, 32'h2);
    rd(2'd0, d); chk(d[8] == 1'b0, "R9 busy cleared", d, 0);
    chk(!mv_req && !mem_req, "R9 requests dropped", {mv_req, mem_req}, 0);
    rd(2'd1, d); chk(d == 0, "R9 qbase cleared", d, 0);
    chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 0);
    repeat (40) @(negedge clk);
    chk(log_n == 0, "R9 aborted move not completed", 32'(log_n), 0);
    mv_lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_qbase_align();
    t_plain_chain();
    t_w1c();
    t_skip_zero();
    t_max_len();
    t_skip_end();
    t_start_busy();
    t_soft_reset();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule